// File: doc/BRIEF.md
# Superscalar Micro-op Dispatch Stage

This block sits between an in-order queue of decoded instructions and the out-of-order back end. Each cycle it looks at the oldest few queued instructions and decides which of them enter the back end together as one dispatch group. An instruction enters only if the group still has micro-op room, and only if the reorder buffer, the rename register pool, its target scheduler and the load or store queue can all take it. The first instruction that cannot go closes the group, so dispatch stays in program order.

Resource availability arrives as free-entry credit counts on plain input ports. Per-slot accept bits form the ready side of a valid/ready handshake with the queue. Alongside the dispatch decision the block keeps one counter per stall cause. It also keeps a histogram of how many micro-ops left in each cycle, which performance analysis reads to find back-end bottlenecks.

Top module: `dispatch_stage`

## Requirements
- R1: Slot 0 is the oldest instruction. An accepted slot has its valid bit set, and the accepted slots always form a contiguous run starting at slot 0. An invalid slot or a blocked instruction stops every younger slot in that cycle.
- R2: The group width W is counted in micro-ops. W is the DISPATCH_W parameter, or DEFAULT_W when DISPATCH_W is 0. An instruction joins only while the group's micro-ops plus its own do not exceed W.
- R3: Each instruction takes as many reorder-buffer entries as it has micro-ops. The summed micro-ops of the accepted instructions never exceed rob_free.
- R4: The destination counts of the accepted instructions may not exceed prf_free. When the PRF_SIZE parameter is 0, the register pool is unbounded and prf_free is ignored.
- R5: Each micro-op takes one entry in the scheduler chosen by its in_sched field. The field selects the CREDIT_W-bit slice k of sched_free.
- R6: A load takes one load-queue entry out of lq_free, and a store takes one store-queue entry out of sq_free.
- R7: An instruction with its solo bit set dispatches only as the oldest instruction of its group. No instruction follows it in the same cycle.
- R8: In a cycle where a valid instruction is blocked by a resource or group cause, exactly one stall counter increments. The counters sit in stall_cnt as CNT_W-bit slices with these indices: 0 register, 1 reorder buffer, 2 scheduler, 3 load queue, 4 store queue, 5 group restriction. No counter moves when the block comes from the width limit or from an invalid slot.
- R9: When several causes block the same instruction, the checks are taken in this order: width, group restriction, reorder buffer, register, scheduler, load queue, store queue. The first failing check names the stall.
- R10: In every cycle after reset, histogram slice n of hist_cnt, for n from 0 to W, increments, where n is the number of micro-ops dispatched in that cycle.
- R11: Reset clears every stall counter and every histogram bin to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | W | Slot holds an instruction |
| in_uops | input | W*UOP_W | Micro-op count per slot (1 or more) |
| in_dests | input | W*DEST_W | Destination registers to rename per slot |
| in_sched | input | W*SW | Target scheduler index per slot |
| in_is_load | input | W | Slot is a load |
| in_is_store | input | W | Slot is a store |
| in_solo | input | W | Slot must dispatch alone at group head |
| rob_free | input | CREDIT_W | Free reorder-buffer entries |
| prf_free | input | CREDIT_W | Free rename registers |
| sched_free | input | NUM_SCHED*CREDIT_W | Free entries per scheduler |
| lq_free | input | CREDIT_W | Free load-queue entries |
| sq_free | input | CREDIT_W | Free store-queue entries |
| in_accept | output | W | Slot dispatched this cycle (ready) |
| stall_cnt | output | 6*CNT_W | Per-cause stall counters |
| hist_cnt | output | (W+1)*CNT_W | Micro-ops-per-cycle histogram |

## Verification
The main build uses an explicit width of four, two schedulers and a finite register pool. Multi-micro-op instructions can then fill the group early, and every one of the six stall causes, plus their priority, can be provoked in isolation. A second build sets the width parameter and the register size to zero. This reaches the default two-wide group and shows a group dispatching with no free rename registers and no rename stall counted.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    typedef enum logic [3:0] {
        BLK_NONE,
        BLK_EMPTY,
        BLK_WIDTH,
        BLK_GROUP,
        BLK_ROB,
        BLK_REG,
        BLK_SCHED,
        BLK_LQ,
        BLK_SQ
    } blk_e;

    localparam int STALL_KINDS = 6;
    localparam int ST_REG      = 0;
    localparam int ST_ROB      = 1;
    localparam int ST_SCHED    = 2;
    localparam int ST_LQ       = 3;
    localparam int ST_SQ       = 4;
    localparam int ST_GROUP    = 5;

    // Maps a blocking reason to its counter slot, -1 when no stall is counted.
    function automatic int stall_slot(blk_e b);
        case (b)
            BLK_REG:   return ST_REG;
            BLK_ROB:   return ST_ROB;
            BLK_SCHED: return ST_SCHED;
            BLK_LQ:    return ST_LQ;
            BLK_SQ:    return ST_SQ;
            BLK_GROUP: return ST_GROUP;
            default:   return -1;
        endcase
    endfunction

endpackage

// File: rtl/dsp_group_builder.sv
module dsp_group_builder #(
    parameter int W              = 4,
    parameter int UOP_W          = 2,
    parameter int DEST_W         = 2,
    parameter int SW             = 1,
    parameter int NUM_SCHED      = 2,
    parameter int CREDIT_W       = 6,
    parameter bit RENAME_LIMITED = 1'b1,
    parameter int GW             = 3
) (
    input  logic [W-1:0]                  in_valid,
    input  logic [W*UOP_W-1:0]            in_uops,
    input  logic [W*DEST_W-1:0]           in_dests,
    input  logic [W*SW-1:0]               in_sched,
    input  logic [W-1:0]                  in_is_load,
    input  logic [W-1:0]                  in_is_store,
    input  logic [W-1:0]                  in_solo,
    input  logic [CREDIT_W-1:0]           rob_free,
    input  logic [CREDIT_W-1:0]           prf_free,
    input  logic [NUM_SCHED*CREDIT_W-1:0] sched_free,
    input  logic [CREDIT_W-1:0]           lq_free,
    input  logic [CREDIT_W-1:0]           sq_free,
    output logic [W-1:0]                  accept,
    output dsp_pkg::blk_e                 first_blk,
    output logic [GW-1:0]                 grp_uops
);
    import dsp_pkg::*;

    localparam int AW = CREDIT_W + 2;

    // Per-slot fields, widened to the accumulator width.
    logic [AW-1:0] slot_u [W];
    logic [AW-1:0] slot_d [W];
    int            slot_s [W];

    for (genvar g = 0; g < W; g++) begin : g_unpack
        assign slot_u[g] = AW'(in_uops[g*UOP_W +: UOP_W]);
        assign slot_d[g] = AW'(in_dests[g*DEST_W +: DEST_W]);
        assign slot_s[g] = int'(in_sched[g*SW +: SW]);
    end

    always_comb begin : build
        logic [AW-1:0] g_u, rob_u, prf_u, lq_u, sq_u;
        logic [AW-1:0] sch_u [NUM_SCHED];
        logic          stop, solo_in, sch_bad;
        blk_e          c;

        g_u       = '0;
        rob_u     = '0;
        prf_u     = '0;
        lq_u      = '0;
        sq_u      = '0;
        stop      = 1'b0;
        solo_in   = 1'b0;
        accept    = '0;
        first_blk = BLK_NONE;
        for (int k = 0; k < NUM_SCHED; k++) sch_u[k] = '0;

        for (int i = 0; i < W; i++) begin
            sch_bad = 1'b1;
            for (int k = 0; k < NUM_SCHED; k++) begin
                if (slot_s[i] == k)
                    sch_bad = (sch_u[k] + slot_u[i]) > AW'(sched_free[k*CREDIT_W +: CREDIT_W]);
            end

            // Fixed check order: the first failing check names the stall.
            if (!in_valid[i])
                c = BLK_EMPTY;
            else if ((g_u + slot_u[i]) > AW'(W))
                c = BLK_WIDTH;
            else if (solo_in || (in_solo[i] && i != 0))
                c = BLK_GROUP;
            else if ((rob_u + slot_u[i]) > AW'(rob_free))
                c = BLK_ROB;
            else if (RENAME_LIMITED && ((prf_u + slot_d[i]) > AW'(prf_free)))
                c = BLK_REG;
            else if (sch_bad)
                c = BLK_SCHED;
            else if (in_is_load[i] && ((lq_u + AW'(1)) > AW'(lq_free)))
                c = BLK_LQ;
            else if (in_is_store[i] && ((sq_u + AW'(1)) > AW'(sq_free)))
                c = BLK_SQ;
            else
                c = BLK_NONE;

            if (!stop) begin
                if (c == BLK_NONE) begin
                    accept[i] = 1'b1;
                    g_u       = g_u + slot_u[i];
                    rob_u     = rob_u + slot_u[i];
                    prf_u     = prf_u + slot_d[i];
                    if (in_is_load[i])  lq_u = lq_u + AW'(1);
                    if (in_is_store[i]) sq_u = sq_u + AW'(1);
                    for (int k = 0; k < NUM_SCHED; k++) begin
                        if (slot_s[i] == k) sch_u[k] = sch_u[k] + slot_u[i];
                    end
                    solo_in = solo_in | in_solo[i];
                end else begin
                    stop      = 1'b1;
                    first_blk = c;
                end
            end
        end

        grp_uops = GW'(g_u);
    end

endmodule

// File: rtl/dsp_stats.sv
module dsp_stats #(
    parameter int W     = 4,
    parameter int GW    = 3,
    parameter int CNT_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  dsp_pkg::blk_e                        first_blk,
    input  logic [GW-1:0]                        grp_uops,
    output logic [dsp_pkg::STALL_KINDS*CNT_W-1:0] stall_cnt,
    output logic [(W+1)*CNT_W-1:0]               hist_cnt
);
    import dsp_pkg::*;

    typedef struct packed {
        logic [STALL_KINDS-1:0][CNT_W-1:0] stall;
        logic [W:0][CNT_W-1:0]             hist;
    } stats_t;

    stats_t st_d, st_q;
    int     slot_idx;

    always_comb begin
        st_d     = st_q;
        slot_idx = stall_slot(first_blk);
        for (int k = 0; k < STALL_KINDS; k++) begin
            if (slot_idx == k) st_d.stall[k] = st_q.stall[k] + CNT_W'(1);
        end
        for (int n = 0; n <= W; n++) begin
            if (int'(grp_uops) == n) st_d.hist[n] = st_q.hist[n] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_cnt = st_q.stall;
    assign hist_cnt  = st_q.hist;

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage #(
    parameter int DISPATCH_W = 4,
    parameter int DEFAULT_W  = 2,
    parameter int NUM_SCHED  = 2,
    parameter int UOP_W      = 2,
    parameter int DEST_W     = 2,
    parameter int CREDIT_W   = 6,
    parameter int CNT_W      = 16,
    parameter int PRF_SIZE   = 64,
    localparam int W  = (DISPATCH_W == 0) ? DEFAULT_W : DISPATCH_W,
    localparam int SW = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
    localparam int NC = dsp_pkg::STALL_KINDS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [W-1:0]                  in_valid,
    input  logic [W*UOP_W-1:0]            in_uops,
    input  logic [W*DEST_W-1:0]           in_dests,
    input  logic [W*SW-1:0]               in_sched,
    input  logic [W-1:0]                  in_is_load,
    input  logic [W-1:0]                  in_is_store,
    input  logic [W-1:0]                  in_solo,
    input  logic [CREDIT_W-1:0]           rob_free,
    input  logic [CREDIT_W-1:0]           prf_free,
    input  logic [NUM_SCHED*CREDIT_W-1:0] sched_free,
    input  logic [CREDIT_W-1:0]           lq_free,
    input  logic [CREDIT_W-1:0]           sq_free,
    output logic [W-1:0]                  in_accept,
    output logic [NC*CNT_W-1:0]           stall_cnt,
    output logic [(W+1)*CNT_W-1:0]        hist_cnt
);
    localparam int GW             = $clog2(W + 1);
    localparam bit RENAME_LIMITED = (PRF_SIZE != 0);

    dsp_pkg::blk_e first_blk;
    logic [GW-1:0] grp_uops;

    dsp_group_builder #(
        .W(W), .UOP_W(UOP_W), .DEST_W(DEST_W), .SW(SW), .NUM_SCHED(NUM_SCHED),
        .CREDIT_W(CREDIT_W), .RENAME_LIMITED(RENAME_LIMITED), .GW(GW)
    ) u_builder (
        .in_valid(in_valid), .in_uops(in_uops), .in_dests(in_dests),
        .in_sched(in_sched), .in_is_load(in_is_load), .in_is_store(in_is_store),
        .in_solo(in_solo), .rob_free(rob_free), .prf_free(prf_free),
        .sched_free(sched_free), .lq_free(lq_free), .sq_free(sq_free),
        .accept(in_accept), .first_blk(first_blk), .grp_uops(grp_uops)
    );

    dsp_stats #(.W(W), .GW(GW), .CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .first_blk(first_blk), .grp_uops(grp_uops),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
    );

endmodule

// File: rtl/dispatch_stage_chk.sv
module dispatch_stage_chk #(
    parameter int W        = 4,
    parameter int UOP_W    = 2,
    parameter int CREDIT_W = 6,
    parameter int CNT_W    = 16,
    parameter int NC       = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [W-1:0]           in_valid,
    input logic [W*UOP_W-1:0]     in_uops,
    input logic [W-1:0]           in_accept,
    input logic [CREDIT_W-1:0]    rob_free,
    input logic [NC*CNT_W-1:0]    stall_cnt,
    input logic [(W+1)*CNT_W-1:0] hist_cnt
);
    logic [CREDIT_W+3:0] acc_uops;
    logic [CNT_W-1:0]    hist_total;
    logic [NC*CNT_W-1:0] stall_prev_q;
    logic [NC-1:0]       stall_moved;

    always_comb begin
        acc_uops = '0;
        for (int i = 0; i < W; i++)
            if (in_accept[i]) acc_uops = acc_uops + (CREDIT_W+4)'(in_uops[i*UOP_W +: UOP_W]);
        hist_total = '0;
        for (int n = 0; n <= W; n++) hist_total = hist_total + hist_cnt[n*CNT_W +: CNT_W];
        for (int k = 0; k < NC; k++)
            stall_moved[k] = stall_cnt[k*CNT_W +: CNT_W] != stall_prev_q[k*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_prev_q <= '0;
        else        stall_prev_q <= stall_cnt;
    end

    // R1
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_accept & ~in_valid) == '0);

    // R1
    accept_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_accept + W'(1)) & in_accept) == '0);

    // R2
    group_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_uops <= (CREDIT_W+4)'(W));

    // R3
    rob_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_uops <= (CREDIT_W+4)'(rob_free));

    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stall_moved) <= 1);

    // R10
    hist_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hist_total == $past(hist_total) + CNT_W'(1));

endmodule

bind dispatch_stage dispatch_stage_chk #(
    .W(W), .UOP_W(UOP_W), .CREDIT_W(CREDIT_W), .CNT_W(CNT_W), .NC(NC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
    .in_accept(in_accept), .rob_free(rob_free), .stall_cnt(stall_cnt),
    .hist_cnt(hist_cnt)
);

// File: tb/dispatch_stage_bench.sv
module dispatch_stage_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 4;
    localparam int W2  = 2;
    localparam int UW  = 2;
    localparam int DW  = 2;
    localparam int NS  = 2;
    localparam int CW  = 6;
    localparam int CN  = 16;
    localparam int NC  = 6;
    localparam int S_REG = 0, S_ROB = 1, S_SCH = 2, S_LQ = 3, S_SQ = 4, S_GRP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // main build
    logic [W-1:0]     m_valid, m_ld, m_st, m_solo, m_acc;
    logic [W*UW-1:0]  m_uops;
    logic [W*DW-1:0]  m_dests;
    logic [W-1:0]     m_sched;
    logic [CW-1:0]    m_rob, m_prf, m_lq, m_sq;
    logic [NS*CW-1:0] m_schf;
    logic [NC*CN-1:0] m_stall;
    logic [(W+1)*CN-1:0] m_hist;

    dispatch_stage #(.DISPATCH_W(W), .DEFAULT_W(2), .NUM_SCHED(NS), .UOP_W(UW),
        .DEST_W(DW), .CREDIT_W(CW), .CNT_W(CN), .PRF_SIZE(64)) u_dispatch_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(m_valid), .in_uops(m_uops),
        .in_dests(m_dests), .in_sched(m_sched), .in_is_load(m_ld), .in_is_store(m_st),
        .in_solo(m_solo), .rob_free(m_rob), .prf_free(m_prf), .sched_free(m_schf),
        .lq_free(m_lq), .sq_free(m_sq), .in_accept(m_acc), .stall_cnt(m_stall),
        .hist_cnt(m_hist));

    // default-width, unbounded-rename build
    logic [W2-1:0]     b_valid, b_zero, b_acc;
    logic [W2*UW-1:0]  b_uops;
    logic [W2*DW-1:0]  b_dests;
    logic [NC*CN-1:0]  b_stall;
    logic [(W2+1)*CN-1:0] b_hist;

    dispatch_stage #(.DISPATCH_W(0), .DEFAULT_W(W2), .NUM_SCHED(NS), .UOP_W(UW),
        .DEST_W(DW), .CREDIT_W(CW), .CNT_W(CN), .PRF_SIZE(0)) u_dispatch_stage_unb (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_uops(b_uops),
        .in_dests(b_dests), .in_sched(b_zero), .in_is_load(b_zero), .in_is_store(b_zero),
        .in_solo(b_zero), .rob_free(CW'(32)), .prf_free(CW'(0)), .sched_free({NS{CW'(16)}}),
        .lq_free(CW'(8)), .sq_free(CW'(8)), .in_accept(b_acc), .stall_cnt(b_stall),
        .hist_cnt(b_hist));

    typedef struct {
        logic [W-1:0] acc;
        int           sidx;
        int           hidx;
        string        req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        m_valid = '0; m_ld = '0; m_st = '0; m_solo = '0; m_sched = '0;
        m_uops = {W{UW'(1)}}; m_dests = '0;
        m_rob = CW'(32); m_prf = CW'(32); m_lq = CW'(8); m_sq = CW'(8);
        m_schf = {NS{CW'(16)}};
    endtask

    task automatic start_item();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_slot(int i, int u, int d, int s, bit ld, bit st, bit solo);
        m_valid[i] = 1'b1;
        m_uops[i*UW +: UW] = UW'(u);
        m_dests[i*DW +: DW] = DW'(d);
        m_sched[i] = s[0];
        m_ld[i] = ld; m_st[i] = st; m_solo[i] = solo;
    endtask

    task automatic push(logic [W-1:0] acc, int sidx, int hidx, string req);
        exp_t it;
        it.acc = acc; it.sidx = sidx; it.hidx = hidx; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: compares accept before the edge, counter deltas after it
    initial begin : monitor
        exp_t it;
        int   pre_s [NC];
        int   pre_h [W+1];
        bit   ok;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                check(m_acc == it.acc, it.req, "accept mask", int'(m_acc), int'(it.acc));
                for (int k = 0; k < NC; k++) pre_s[k] = int'(m_stall[k*CN +: CN]);
                for (int n = 0; n <= W; n++) pre_h[n] = int'(m_hist[n*CN +: CN]);
                @(posedge clk);
                #1;
                ok = 1'b1;
                for (int k = 0; k < NC; k++)
                    if (int'(m_stall[k*CN +: CN]) - pre_s[k] != ((k == it.sidx) ? 1 : 0)) ok = 1'b0;
                check(ok, it.req, "stall counter index moved", ok ? it.sidx : -2, it.sidx);
                ok = 1'b1;
                for (int n = 0; n <= W; n++)
                    if (int'(m_hist[n*CN +: CN]) - pre_h[n] != ((n == it.hidx) ? 1 : 0)) ok = 1'b0;
                check(ok, it.req, "histogram bin moved", ok ? it.hidx : -2, it.hidx);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        check(1'b0, "watchdog", "run completed", 0, 1);
        finish_run();
    end

    initial begin : driver
        idle_inputs();
        b_valid = '0; b_zero = '0; b_uops = {W2{UW'(1)}}; b_dests = '0;
        repeat (3) @(negedge clk);
        // R11: counters are clear while in reset
        check(m_stall == '0, "R11", "stall counters in reset", int'(m_stall != '0), 0);
        check(m_hist == '0, "R11", "histogram in reset", int'(m_hist != '0), 0);
        rst_n = 1'b1;

        // R2: four single micro-ops fill the group
        start_item(); for (int i = 0; i < 4; i++) set_slot(i, 1, 0, 0, 0, 0, 0);
        push(4'b1111, -1, 4, "R2");
        // R2: micro-op width limit, no stall counted
        start_item(); set_slot(0, 2, 0, 0, 0, 0, 0); set_slot(1, 2, 0, 0, 0, 0, 0);
        set_slot(2, 1, 0, 0, 0, 0, 0);
        push(4'b0011, -1, 4, "R2");
        // R3: reorder buffer cost equals micro-op count
        start_item(); m_rob = CW'(3);
        set_slot(0, 1, 0, 0, 0, 0, 0); set_slot(1, 1, 0, 0, 0, 0, 0);
        set_slot(2, 2, 0, 0, 0, 0, 0); set_slot(3, 1, 0, 0, 0, 0, 0);
        push(4'b0011, S_ROB, 2, "R3");
        // R4: rename registers exhausted
        start_item(); m_prf = CW'(1);
        set_slot(0, 1, 1, 0, 0, 0, 0); set_slot(1, 1, 1, 0, 0, 0, 0);
        push(4'b0001, S_REG, 1, "R4");
        // R5 and R1: scheduler 0 full, younger fitting slot still held back
        start_item(); m_schf[0 +: CW] = CW'(1);
        set_slot(0, 1, 0, 0, 0, 0, 0); set_slot(1, 1, 0, 1, 0, 0, 0);
        set_slot(2, 1, 0, 0, 0, 0, 0); set_slot(3, 1, 0, 1, 0, 0, 0);
        push(4'b0011, S_SCH, 2, "R5");
        // R6: load queue full
        start_item(); m_lq = CW'(0); set_slot(0, 1, 0, 0, 1, 0, 0);
        push(4'b0000, S_LQ, 0, "R6");
        // R6: one store entry for two stores
        start_item(); m_sq = CW'(1);
        set_slot(0, 1, 0, 0, 0, 1, 0); set_slot(1, 1, 0, 0, 0, 1, 0);
        push(4'b0001, S_SQ, 1, "R6");
        // R7: solo instruction not at group head
        start_item(); set_slot(0, 1, 0, 0, 0, 0, 0); set_slot(1, 1, 0, 0, 0, 0, 1);
        push(4'b0001, S_GRP, 1, "R7");
        // R7: nothing follows a solo instruction
        start_item(); set_slot(0, 1, 0, 0, 0, 0, 1); set_slot(1, 1, 0, 0, 0, 0, 0);
        push(4'b0001, S_GRP, 1, "R7");
        // R9: reorder buffer beats register and load queue
        start_item(); m_rob = CW'(0); m_prf = CW'(0); m_lq = CW'(0);
        set_slot(0, 1, 1, 0, 1, 0, 0);
        push(4'b0000, S_ROB, 0, "R9");
        // R9: width beats reorder buffer, no stall
        start_item(); m_rob = CW'(3);
        set_slot(0, 3, 0, 0, 0, 0, 0); set_slot(1, 2, 0, 0, 0, 0, 0);
        push(4'b0001, -1, 3, "R9");
        // R1: invalid slot stops the group, no stall
        start_item(); set_slot(0, 1, 0, 0, 0, 0, 0); set_slot(2, 1, 0, 0, 0, 0, 0);
        set_slot(3, 1, 0, 0, 0, 0, 0);
        push(4'b0001, -1, 1, "R1");
        // R8 and R10: empty queue counts in bin 0 with no stall
        start_item();
        push(4'b0000, -1, 0, "R10");

        start_item();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

        // R2 and R4 on the default-width build with an unbounded register pool
        @(negedge clk);
        b_valid = 2'b11; b_uops = {UW'(1), UW'(1)}; b_dests = {DW'(2), DW'(2)};
        #(CLK_PERIOD/4);
        check(b_acc == 2'b11, "R4", "unbounded rename accept", int'(b_acc), 3);
        @(posedge clk); #1;
        check(int'(b_hist[2*CN +: CN]) == 1, "R2", "default width bin 2", int'(b_hist[2*CN +: CN]), 1);
        check(b_stall == '0, "R4", "no rename stall when unbounded", int'(b_stall[0 +: CN]), 0);
        @(negedge clk);
        b_uops = {UW'(1), UW'(2)};
        #(CLK_PERIOD/4);
        check(b_acc == 2'b01, "R2", "default width of two micro-ops", int'(b_acc), 1);
        @(negedge clk);
        b_valid = '0;
        finish_run();
    end

endmodule